// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output line. A byte enters a holding register through a write strobe. When the shift register is free, the byte moves into it at once. The frame then goes out as a low start bit, the active data bits least significant bit first, an optional parity bit and a high stop period. The line idles high between frames.

Bit timing comes from an external tick enable that pulses at sixteen times the bit rate, so every bit lasts sixteen ticks. The word length (five to eight bits), parity enable, even or odd parity and stop length are configuration inputs. They are sampled at the moment a byte enters the shifter. Two flags report the buffers: one shows that the holding register can take a new byte, and the other shows that the transmitter has gone completely quiet.

Top module: `async_tx`

## Requirements
- R1: After reset `txd_o` is 1, `hold_empty_o` is 1 and `shift_empty_o` is 1.
- R2: A frame is sent in this order: one start bit at 0, the data bits least significant bit first, the parity bit when enabled, then the stop period at 1.
- R3: `wlen_i` selects the number of data bits: code 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the selected length are not sent.
- R4: When `par_en_i` is 1, one parity bit follows the data bits. With `par_odd_i` at 0 the count of ones over the active data bits and the parity bit is even; with `par_odd_i` at 1 it is odd. When `par_en_i` is 0, no parity bit is sent.
- R5: The start, data and parity bits each last 16 ticks of `tick_i`. The stop period lasts 16 ticks when `stop_long_i` is 0. When `stop_long_i` is 1 it lasts 32 ticks, or 24 ticks if the word length is 5.
- R6: `hold_empty_o` falls on the clock edge that registers a write. It rises on the edge where the byte moves into the idle shifter, which is the next edge. A byte written during a frame starts on the edge that ends the current stop period, with no idle gap.
- R7: `shift_empty_o` is 1 only while the holding register is empty, no frame is in progress and the last stop period has ended.
- R8: A write while the holding register is full replaces the pending byte without any error indication. Only the latest byte is sent.
- R9: The configuration inputs are captured when a byte enters the shifter. Changing them during a frame does not alter that frame.
- R10: While a frame is in progress and the holding register is empty, `txd_o` changes only on clock edges where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Enable pulse at 16 times the bit rate |
| wr_i | input | 1 | Write strobe for the holding register |
| wdata_i | input | 8 | Byte to transmit |
| wlen_i | input | 2 | Word length code (data bits minus 5) |
| par_en_i | input | 1 | Parity bit enable |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| stop_long_i | input | 1 | 1 selects the long stop period |
| txd_o | output | 1 | Serial output, idles high |
| hold_empty_o | output | 1 | Holding register can take a byte |
| shift_empty_o | output | 1 | Holding and shift registers empty and the line idle |

## Verification
A wrong bit counter or a wrong bit index shows up as a misplaced edge on `txd_o`, or as a wrong total number of ticks before `shift_empty_o` rises. The bench samples the line in the middle of each bit and counts ticks, so such a fault is seen within the frame it corrupts. A fault in handing bytes from the holding register to the shifter shows on `hold_empty_o` one edge after a write. It also shows as a lost, repeated or stale byte in the frame that follows.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_STOP
  } tx_state_e;
endpackage

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else begin
      // a write in the same cycle as a take refills the register
      if (wr_i) begin
        full_o <= 1'b1;
        data_o <= wdata_i;
      end else if (take_i) begin
        full_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/async_tx_parity.sv
module async_tx_parity #(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 5,
  localparam int WLEN_W = $clog2(DATA_W - MIN_W + 1)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [WLEN_W-1:0] wlen_i,
  input  logic              odd_i,
  output logic              par_o
);
  always_comb begin
    par_o = odd_i;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < MIN_W + int'(wlen_i)) par_o = par_o ^ data_i[i];
    end
  end
endmodule

// File: rtl/async_tx_shift.sv
module async_tx_shift
  import async_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 5,
  parameter int OVS    = 16,
  localparam int WLEN_W = $clog2(DATA_W - MIN_W + 1),
  localparam int CNT_W  = $clog2(2 * OVS + 1),
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              hold_full_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic [WLEN_W-1:0] wlen_i,
  input  logic              par_en_i,
  input  logic              par_i,
  input  logic              stop_long_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              txd_o
);
  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  bit_lim;
  logic [CNT_W-1:0]  stop_lim_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  last_idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              pen_q;
  logic              par_q;
  logic              bit_end;

  assign bit_lim = (state_q == TX_STOP) ? stop_lim_q : CNT_W'(OVS);
  assign bit_end = tick_i && (cnt_q == bit_lim - CNT_W'(1));
  assign take_o  = hold_full_i && ((state_q == TX_IDLE) || (state_q == TX_STOP && bit_end));
  assign busy_o  = (state_q != TX_IDLE);

  always_comb begin
    unique case (state_q)
      TX_START: txd_o = 1'b0;
      TX_DATA:  txd_o = shreg_q[0];
      TX_PAR:   txd_o = par_q;
      default:  txd_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= TX_IDLE;
      cnt_q      <= '0;
      stop_lim_q <= CNT_W'(OVS);
      idx_q      <= '0;
      last_idx_q <= '0;
      shreg_q    <= '0;
      pen_q      <= 1'b0;
      par_q      <= 1'b0;
    end else if (take_o) begin
      // frame configuration is frozen here
      state_q    <= TX_START;
      cnt_q      <= '0;
      idx_q      <= '0;
      shreg_q    <= hold_data_i;
      last_idx_q <= IDX_W'(MIN_W - 1) + IDX_W'(wlen_i);
      pen_q      <= par_en_i;
      par_q      <= par_i;
      if (!stop_long_i)        stop_lim_q <= CNT_W'(OVS);
      else if (wlen_i == '0)   stop_lim_q <= CNT_W'(OVS + OVS / 2);
      else                     stop_lim_q <= CNT_W'(2 * OVS);
    end else if (tick_i && state_q != TX_IDLE) begin
      if (!bit_end) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end else begin
        cnt_q <= '0;
        unique case (state_q)
          TX_START: state_q <= TX_DATA;
          TX_DATA: begin
            shreg_q <= shreg_q >> 1;
            if (idx_q == last_idx_q) state_q <= pen_q ? TX_PAR : TX_STOP;
            else                     idx_q <= idx_q + IDX_W'(1);
          end
          TX_PAR:  state_q <= TX_STOP;
          default: state_q <= TX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/async_tx.sv
module async_tx #(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 5,
  parameter int OVS    = 16,
  localparam int WLEN_W = $clog2(DATA_W - MIN_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WLEN_W-1:0] wlen_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop_long_i,
  output logic              txd_o,
  output logic              hold_empty_o,
  output logic              shift_empty_o
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              busy;
  logic              par;

  async_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .take_i  (take),
    .full_o  (hold_full),
    .data_o  (hold_data)
  );

  async_tx_parity #(.DATA_W(DATA_W), .MIN_W(MIN_W)) u_par (
    .data_i (hold_data),
    .wlen_i (wlen_i),
    .odd_i  (par_odd_i),
    .par_o  (par)
  );

  async_tx_shift #(.DATA_W(DATA_W), .MIN_W(MIN_W), .OVS(OVS)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .wlen_i      (wlen_i),
    .par_en_i    (par_en_i),
    .par_i       (par),
    .stop_long_i (stop_long_i),
    .take_o      (take),
    .busy_o      (busy),
    .txd_o       (txd_o)
  );

  assign hold_empty_o  = ~hold_full;
  assign shift_empty_o = ~hold_full & ~busy;
endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic wr_i,
  input logic txd_o,
  input logic hold_empty_o,
  input logic shift_empty_o
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_empty_o |-> txd_o); // R2
  AST_WRITE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !hold_empty_o); // R6
  AST_QUIET_NEEDS_HOLD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_empty_o |-> hold_empty_o); // R7
  AST_HOLD_STAYS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_empty_o && !wr_i) |=> hold_empty_o); // R6
  AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !shift_empty_o && hold_empty_o) |=> $stable(txd_o)); // R10
endmodule

bind async_tx async_tx_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_i        (tick_i),
  .wr_i          (wr_i),
  .txd_o         (txd_o),
  .hold_empty_o  (hold_empty_o),
  .shift_empty_o (shift_empty_o)
);

// File: tb/sim_async_tx.sv
`timescale 1ns/1ps
module sim_async_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [1:0] wlen = 2'd3;
  logic       pen = 1'b0;
  logic       podd = 1'b0;
  logic       slong = 1'b0;
  logic       txd, hold_empty, shift_empty;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [1:0] div = '0;

  // monitor state
  logic        mon_run = 1'b0;
  int          mon_t = 0;
  int          mon_n = 0;
  int          mon_frames = 0;
  logic [63:0] mon_v = '0;

  always #10 clk = ~clk;

  async_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .wdata_i(wdata),
    .wlen_i(wlen), .par_en_i(pen), .par_odd_i(podd), .stop_long_i(slong),
    .txd_o(txd), .hold_empty_o(hold_empty), .shift_empty_o(shift_empty)
  );

  // tick every 4 clocks
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div  <= '0;
      tick <= 1'b0;
    end else begin
      div  <= div + 2'd1;
      tick <= (div == 2'd3);
    end
  end

  // line monitor: sample mid-bit, count ticks until the line goes quiet
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mon_run && !txd) begin
        mon_run = 1'b1;
        mon_t = 0;
        mon_n = 0;
        mon_v = '0;
      end
      if (mon_run) begin
        if (shift_empty) begin
          mon_run = 1'b0;
          mon_frames = mon_frames + 1;
        end else if (tick) begin
          mon_t = mon_t + 1;
          if (mon_t % 16 == 8) begin
            mon_v[mon_n] = txd;
            mon_n = mon_n + 1;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // append the expected mid-bit samples and tick count of one frame
  task automatic build(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                       input logic po, input logic sl,
                       inout logic [63:0] v, inout int n, inout int t);
    int nb = 5 + int'(wl);
    int st;
    logic p = po;
    v[n] = 1'b0; n++;
    for (int i = 0; i < nb; i++) begin
      v[n] = d[i]; n++;
      p = p ^ d[i];
    end
    if (pe) begin v[n] = p; n++; end
    st = !sl ? 16 : (wl == 2'd0 ? 24 : 32);
    v[n] = 1'b1; n++;
    if (st > 16) begin v[n] = 1'b1; n++; end
    t = t + 16 * (1 + nb + int'(pe)) + st;
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1;
    wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_frames(input int f0);
    int g = 0;
    while (mon_frames == f0 && g < 20000) begin
      @(posedge clk);
      g++;
    end
    @(negedge clk);
  endtask

  task automatic compare(input string req, input logic [63:0] ev, input int en, input int et);
    logic [63:0] m = (64'd1 << en) - 64'd1;
    chk((mon_v & m) == ev && mon_n == en, req, mon_v & m, ev);
    chk(mon_t == et, req, mon_t, et);
  endtask

  task automatic t_reset;
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(hold_empty == 1'b1, "R1 hold_empty", hold_empty, 1);
    chk(shift_empty == 1'b1, "R1 shift_empty", shift_empty, 1);
  endtask

  task automatic t_frame(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                         input logic po, input logic sl, input string req);
    logic [63:0] ev = '0;
    int en = 0;
    int et = 0;
    int f0 = mon_frames;
    wlen = wl; pen = pe; podd = po; slong = sl;
    build(d, wl, pe, po, sl, ev, en, et);
    write_byte(d);
    wait_frames(f0);
    compare(req, ev, en, et);
    chk(shift_empty == 1'b1, "R7 quiet after frame", shift_empty, 1);
  endtask

  task automatic t_double_buffer;
    logic [63:0] ev = '0;
    int en = 0;
    int et = 0;
    int f0 = mon_frames;
    wlen = 2'd3; pen = 1'b0; podd = 1'b0; slong = 1'b0;
    build(8'h3C, 2'd3, 1'b0, 1'b0, 1'b0, ev, en, et);
    build(8'hC1, 2'd3, 1'b0, 1'b0, 1'b0, ev, en, et);
    write_byte(8'h3C);
    chk(hold_empty == 1'b0, "R6 hold full after write", hold_empty, 0);
    @(negedge clk);
    chk(hold_empty == 1'b1, "R6 hold empty after move", hold_empty, 1);
    chk(shift_empty == 1'b0, "R7 busy during frame", shift_empty, 0);
    wr = 1'b1; wdata = 8'hC1;
    @(negedge clk);
    wr = 1'b0;
    chk(hold_empty == 1'b0, "R6 second byte pending", hold_empty, 0);
    wait_frames(f0);
    compare("R6 back-to-back frames", ev, en, et);
  endtask

  task automatic t_overwrite;
    logic [63:0] ev = '0;
    int en = 0;
    int et = 0;
    int f0 = mon_frames;
    build(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, ev, en, et);
    build(8'h5E, 2'd3, 1'b0, 1'b0, 1'b0, ev, en, et);
    write_byte(8'h81);
    @(negedge clk);
    write_byte(8'hF0);
    write_byte(8'h5E);
    chk(hold_empty == 1'b0, "R8 still one pending", hold_empty, 0);
    wait_frames(f0);
    compare("R8 latest byte only", ev, en, et);
  endtask

  task automatic t_config_freeze;
    logic [63:0] ev = '0;
    int en = 0;
    int et = 0;
    int f0 = mon_frames;
    wlen = 2'd3; pen = 1'b0; podd = 1'b0; slong = 1'b0;
    build(8'hA7, 2'd3, 1'b0, 1'b0, 1'b0, ev, en, et);
    write_byte(8'hA7);
    @(negedge clk);
    wlen = 2'd0; pen = 1'b1; podd = 1'b1; slong = 1'b1;
    wait_frames(f0);
    compare("R9 config frozen", ev, en, et);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_frame(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, "R2 R5 8-bit one stop");
    t_frame(8'hF3, 2'd0, 1'b0, 1'b0, 1'b1, "R3 R5 5-bit one-and-a-half stop");
    t_frame(8'h2D, 2'd1, 1'b1, 1'b0, 1'b0, "R4 6-bit even parity");
    t_frame(8'h6B, 2'd2, 1'b1, 1'b1, 1'b1, "R4 R5 7-bit odd parity two stop");
    t_frame(8'hE1, 2'd0, 1'b1, 1'b0, 1'b0, "R3 R4 upper bits ignored");
    t_frame(8'h00, 2'd3, 1'b1, 1'b1, 1'b1, "R4 R5 odd parity zero data");
    t_double_buffer();
    t_overwrite();
    t_config_freeze();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule